// File: doc/BRIEF.md
# Ping-Pong Endpoint Register Bank

This block holds the transfer parameters for the four endpoints of a USB device controller. Each endpoint has two register sets, A and B. Firmware fills one set while the transfer engine runs on the other. Each set has five byte-wide registers: control, buffer base, buffer length, packet status and transfer count. A byte-wide microcontroller bus reaches these registers through a register index. The bus is a plain write strobe plus a combinational read path. It has no handshake, because every access finishes in one cycle.

When the transfer engine pulses the completion strobe for an endpoint, three things happen in that cycle. The status and residual count of the finished transfer are written into the set that was in use. That set is disarmed. The endpoint then switches to its other set. The transfer engine reads the base, length and armed state of each endpoint's selected set straight from output pins, together with the selection bit. If the newly selected set is already armed, the next transfer can start without waiting for firmware. Endpoint 3 also drives a DMA enable, which is high while its selected set is armed.

Top module: `ep_pingpong_bank`

## Requirements
- R1: After synchronous reset every register reads zero, every endpoint selects set A (next_sel = 0), act_armed is zero and dma_en is low.
- R2: The index is decoded as bits [5:4] = endpoint, bit 3 = set (0 = A, 1 = B) and bits [2:0] = offset. The offsets are 0 control, 1 base, 2 length, 3 packet status and 4 transfer count. A byte written to offsets 1 to 4 reads back unchanged.
- R3: Control bit 0 is the armed flag and bits 6:1 are plain storage. A read of control bit 7 returns the endpoint's current selection (0 = A, 1 = B), and writes to bit 7 are dropped.
- R4: Offsets 5 to 7 of every slot read as zero, and writes to them change no register.
- R5: A one-cycle completion pulse on xfer_done[n] toggles the selection of endpoint n. The new value is visible on next_sel[n] and in control bit 7 from the following cycle.
- R6: On completion, the set that was selected takes its packet status from xfer_status and its transfer count from xfer_resid, and its armed bit is cleared.
- R7: act_base, act_len and act_armed for endpoint n always show the base, length and armed bit of that endpoint's selected set.
- R8: dma_en equals the armed bit of endpoint 3's selected set. Arming or completing any other endpoint does not change it.
- R9: If a firmware write to the finishing set's control register falls in the same cycle as completion, the armed bit ends up cleared and the other control bits take the written value.
- R10: A completion on one endpoint leaves the selection and registers of every other endpoint unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register index for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| xfer_done | input | 4 | Per-endpoint completion pulse |
| xfer_status | input | 32 | Packet status per endpoint, byte n for endpoint n |
| xfer_resid | input | 32 | Residual count per endpoint, byte n for endpoint n |
| act_base | output | 32 | Selected set's buffer base, byte n per endpoint |
| act_len | output | 32 | Selected set's buffer length, byte n per endpoint |
| act_armed | output | 4 | Selected set's armed bit per endpoint |
| next_sel | output | 4 | Selected set per endpoint (0 = A, 1 = B) |
| dma_en | output | 1 | Endpoint 3 DMA enable |

## Verification
The bench sends back-to-back completions on endpoint 3. In the first the B set is already armed, so dma_en must stay high across the switch. In the second the A set was disarmed by the earlier completion, so dma_en must drop. A design that cleared the wrong set's armed bit, or looked at the non-selected set, would get one of these two cases wrong. The bench also issues a firmware arming write in the same cycle as a completion. If the write were allowed to win, the set would stay armed and an idle transfer could restart.

Writes to the unused offsets are followed by reads of the neighbouring base register. A decoder that aliases offsets 5 to 7 would corrupt that register. Completion on one endpoint is checked against the selection bits of all four endpoints, which catches cross-wired strobes. Control bit 7 is read after each switch, to confirm that it follows the selection and not the written data.

// File: rtl/epbank_pkg.sv
package epbank_pkg;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 3;

  typedef enum logic [OFF_W-1:0] {
    OFF_CTRL = 3'd0,
    OFF_BASE = 3'd1,
    OFF_LEN  = 3'd2,
    OFF_STAT = 3'd3,
    OFF_CNT  = 3'd4
  } reg_off_e;

  typedef struct packed {
    logic [BYTE_W-1:0] ctrl;
    logic [BYTE_W-1:0] base;
    logic [BYTE_W-1:0] len;
    logic [BYTE_W-1:0] stat;
    logic [BYTE_W-1:0] cnt;
  } set_regs_t;

  localparam int ARM_BIT = 0;
  localparam int SEL_BIT = BYTE_W - 1;
endpackage

// File: rtl/epb_set.sv
module epb_set
  import epbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] stat_in,
  input  logic [BYTE_W-1:0] cnt_in,
  output set_regs_t         regs_o
);
  set_regs_t r;

  always_ff @(posedge clk) begin
    if (rst) begin
      r <= '0;
    end else begin
      if (wr_en) begin
        case (wr_off)
          OFF_CTRL: r.ctrl[SEL_BIT-1:0] <= wr_data[SEL_BIT-1:0];
          OFF_BASE: r.base <= wr_data;
          OFF_LEN:  r.len  <= wr_data;
          OFF_STAT: r.stat <= wr_data;
          OFF_CNT:  r.cnt  <= wr_data;
          default: ;
        endcase
      end
      // completion comes last so it overrides a same-cycle firmware write
      if (done_i) begin
        r.stat       <= stat_in;
        r.cnt        <= cnt_in;
        r.ctrl[ARM_BIT] <= 1'b0;
      end
    end
  end

  assign regs_o = r;

  assert_done_disarms_R6: assert property (@(posedge clk) disable iff (rst)
    done_i |=> !regs_o.ctrl[ARM_BIT]);

  assert_done_loads_R6: assert property (@(posedge clk) disable iff (rst)
    done_i |=> (regs_o.stat == $past(stat_in) && regs_o.cnt == $past(cnt_in)));

  assert_arm_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_off == OFF_CTRL && !done_i) |=> regs_o.ctrl[ARM_BIT] == $past(wr_data[ARM_BIT]));

  assert_bit7_clear_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !regs_o.ctrl[SEL_BIT]);
endmodule

// File: rtl/epb_endpoint.sv
module epb_endpoint
  import epbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_set,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] stat_in,
  input  logic [BYTE_W-1:0] cnt_in,
  output set_regs_t [1:0]   sets_o,
  output logic              sel_o,
  output logic [BYTE_W-1:0] act_base_o,
  output logic [BYTE_W-1:0] act_len_o,
  output logic              act_armed_o
);
  logic sel_q;

  for (genvar k = 0; k < 2; k++) begin : g_set
    epb_set u_set (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en && (wr_set == 1'(k))),
      .wr_off  (wr_off),
      .wr_data (wr_data),
      .done_i  (done_i && (sel_q == 1'(k))),
      .stat_in (stat_in),
      .cnt_in  (cnt_in),
      .regs_o  (sets_o[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= 1'b0;
    else if (done_i) sel_q <= ~sel_q;
  end

  assign sel_o       = sel_q;
  assign act_base_o  = sets_o[sel_q].base;
  assign act_len_o   = sets_o[sel_q].len;
  assign act_armed_o = sets_o[sel_q].ctrl[ARM_BIT];

  assert_reset_sel_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sel_o && !act_armed_o));

  assert_flip_R5: assert property (@(posedge clk) disable iff (rst)
    done_i |=> (sel_o != $past(sel_o)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done_i |=> $stable(sel_o));

  assert_new_set_armed_R7: assert property (@(posedge clk) disable iff (rst)
    (done_i && !wr_en) |=> (act_armed_o == $past(sets_o[~sel_q].ctrl[ARM_BIT])));
endmodule

// File: rtl/epb_rdmux.sv
module epb_rdmux
  import epbank_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int ADDR_W = $clog2(NUM_EP) + 4
) (
  input  set_regs_t [2*NUM_EP-1:0] sets_i,
  input  logic [NUM_EP-1:0]        sel_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic [BYTE_W-1:0]        rdata_o
);
  localparam int EP_W = ADDR_W - 4;

  logic [EP_W-1:0]  ep;
  logic             st;
  logic [OFF_W-1:0] off;
  set_regs_t        r;

  always_comb begin
    ep      = addr_i[ADDR_W-1:4];
    st      = addr_i[3];
    off     = addr_i[OFF_W-1:0];
    r       = '0;
    rdata_o = '0;
    if (int'(ep) < NUM_EP) begin
      r = sets_i[{ep, st}];
      case (off)
        OFF_CTRL: rdata_o = {sel_i[ep], r.ctrl[SEL_BIT-1:0]};
        OFF_BASE: rdata_o = r.base;
        OFF_LEN:  rdata_o = r.len;
        OFF_STAT: rdata_o = r.stat;
        OFF_CNT:  rdata_o = r.cnt;
        default:  rdata_o = '0;
      endcase
    end
  end

  always_comb begin
    if (addr_i[OFF_W-1:0] > 3'd4)
      assert_unmapped_zero_R4: assert (rdata_o == '0);
  end
endmodule

// File: rtl/ep_pingpong_bank.sv
module ep_pingpong_bank
  import epbank_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int DMA_EP = 3,
  parameter int ADDR_W = $clog2(NUM_EP) + 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [BYTE_W-1:0]        reg_wdata,
  output logic [BYTE_W-1:0]        reg_rdata,
  input  logic [NUM_EP-1:0]        xfer_done,
  input  logic [NUM_EP*BYTE_W-1:0] xfer_status,
  input  logic [NUM_EP*BYTE_W-1:0] xfer_resid,
  output logic [NUM_EP*BYTE_W-1:0] act_base,
  output logic [NUM_EP*BYTE_W-1:0] act_len,
  output logic [NUM_EP-1:0]        act_armed,
  output logic [NUM_EP-1:0]        next_sel,
  output logic                     dma_en
);
  localparam int EP_W = ADDR_W - 4;

  logic [EP_W-1:0]  a_ep;
  logic             a_set;
  logic [OFF_W-1:0] a_off;
  logic             mapped;
  set_regs_t [2*NUM_EP-1:0] all_sets;

  assign a_ep   = reg_addr[ADDR_W-1:4];
  assign a_set  = reg_addr[3];
  assign a_off  = reg_addr[OFF_W-1:0];
  assign mapped = (a_off <= 3'd4) && (int'(a_ep) < NUM_EP);

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    epb_endpoint u_ep (
      .clk         (clk),
      .rst         (rst),
      .wr_en       (reg_wr && mapped && (a_ep == EP_W'(e))),
      .wr_set      (a_set),
      .wr_off      (a_off),
      .wr_data     (reg_wdata),
      .done_i      (xfer_done[e]),
      .stat_in     (xfer_status[e*BYTE_W +: BYTE_W]),
      .cnt_in      (xfer_resid[e*BYTE_W +: BYTE_W]),
      .sets_o      (all_sets[2*e+1 -: 2]),
      .sel_o       (next_sel[e]),
      .act_base_o  (act_base[e*BYTE_W +: BYTE_W]),
      .act_len_o   (act_len[e*BYTE_W +: BYTE_W]),
      .act_armed_o (act_armed[e])
    );
  end

  epb_rdmux #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_rdmux (
    .sets_i  (all_sets),
    .sel_i   (next_sel),
    .addr_i  (reg_addr),
    .rdata_o (reg_rdata)
  );

  assign dma_en = act_armed[DMA_EP];

  assert_dma_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_en) |-> ($past(reg_wr) || $past(xfer_done[DMA_EP])));

  assert_dma_drop_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(dma_en) |-> ($past(reg_wr) || $past(xfer_done[DMA_EP])));
endmodule

// File: tb/test_ep_pingpong_bank.sv
module test_ep_pingpong_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [3:0]  xfer_done = '0;
  logic [31:0] xfer_status = '0;
  logic [31:0] xfer_resid = '0;
  logic [31:0] act_base, act_len;
  logic [3:0]  act_armed, next_sel;
  logic        dma_en;

  always #5 clk = ~clk;

  ep_pingpong_bank i_ep_pingpong_bank (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
    .xfer_status(xfer_status), .xfer_resid(xfer_resid), .act_base(act_base),
    .act_len(act_len), .act_armed(act_armed), .next_sel(next_sel), .dma_en(dma_en)
  );

  typedef struct {
    int         kind;   // 0 rdata, 1 next_sel, 2 act_armed, 3 dma_en, 4 act_base, 5 act_len
    int         arg;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit ended = 0;

  function automatic logic [7:0] probe(int kind, int arg);
    case (kind)
      0: return reg_rdata;
      1: return {4'h0, next_sel};
      2: return {4'h0, act_armed};
      3: return {7'h0, dma_en};
      4: return act_base[arg*8 +: 8];
      default: return act_len[arg*8 +: 8];
    endcase
  endfunction

  // monitor: pops expectations and compares away from the edge
  always @(posedge clk) begin
    #2;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it = q.pop_front();
      got = probe(it.kind, it.arg);
      compared++;
      if (got !== it.exp) begin
        mismatched++;
        $display("FAIL %s kind=%0d arg=%0h actual=%02h expected=%02h",
                 it.tag, it.kind, it.arg, got, it.exp);
      end
    end
  end

  function automatic logic [5:0] idx(int ep, int st, int off);
    return 6'(ep*16 + st*8 + off);
  endfunction

  function automatic logic [7:0] val(int ep, int st, int off);
    return 8'(ep*32 + st*16 + off*3 + 1);
  endfunction

  task automatic expect_item(int kind, int arg, logic [7:0] exp, string tag);
    item_t it;
    @(negedge clk);
    reg_wr = 1'b0;
    xfer_done = '0;
    if (kind == 0) reg_addr = 6'(arg);
    it.kind = kind; it.arg = arg; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
    #3;
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic done(int ep, logic [7:0] st, logic [7:0] rc);
    @(negedge clk);
    xfer_done[ep] = 1'b1;
    xfer_status[ep*8 +: 8] = st;
    xfer_resid[ep*8 +: 8] = rc;
    @(negedge clk);
    xfer_done = '0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    expect_item(0, idx(0,0,0), 8'h00, "R1 ctrl");
    expect_item(0, idx(3,1,4), 8'h00, "R1 cnt");
    expect_item(1, 0, 8'h00, "R1 next_sel");
    expect_item(2, 0, 8'h00, "R1 act_armed");
    expect_item(3, 0, 8'h00, "R1 dma_en");

    // R2: address map readback of offsets 1..4
    for (int e = 0; e < 4; e++)
      for (int s = 0; s < 2; s++)
        for (int o = 1; o < 5; o++)
          wr(idx(e,s,o), val(e,s,o));
    for (int e = 0; e < 4; e++)
      for (int s = 0; s < 2; s++)
        for (int o = 1; o < 5; o++)
          expect_item(0, idx(e,s,o), val(e,s,o), "R2 readback");

    // R3: control bits, bit 7 reads selection
    wr(idx(1,0,0), 8'hFF);
    expect_item(0, idx(1,0,0), 8'h7F, "R3 ctrl bit7 dropped");
    expect_item(2, 0, 8'h02, "R3 armed via ctrl bit0");

    // R4: unmapped offsets
    for (int o = 5; o < 8; o++) wr(idx(0,0,o), 8'hAA);
    for (int o = 5; o < 8; o++) expect_item(0, idx(0,0,o), 8'h00, "R4 unmapped reads zero");
    expect_item(0, idx(0,0,1), val(0,0,1), "R4 base untouched");
    expect_item(0, idx(0,0,0), 8'h00, "R4 ctrl untouched");

    // R7: active outputs from set A
    expect_item(4, 1, val(1,0,1), "R7 act_base ep1 set A");
    expect_item(5, 2, val(2,0,2), "R7 act_len ep2 set A");

    // R5 R6 R10: completion on ep1
    done(1, 8'h5A, 8'h33);
    expect_item(1, 0, 8'h02, "R5 R10 next_sel after ep1 done");
    expect_item(0, idx(1,0,3), 8'h5A, "R6 status loaded");
    expect_item(0, idx(1,0,4), 8'h33, "R6 count loaded");
    expect_item(0, idx(1,0,0), 8'hFE, "R5 R6 ctrl disarmed, bit7 set");
    expect_item(0, idx(1,1,3), val(1,1,3), "R10 other set status kept");
    expect_item(4, 1, val(1,1,1), "R7 act_base follows set B");
    expect_item(5, 1, val(1,1,2), "R7 act_len follows set B");
    expect_item(2, 0, 8'h00, "R7 act_armed set B idle");

    // R8: DMA enable from endpoint 3
    wr(idx(2,0,0), 8'h01);
    expect_item(3, 0, 8'h00, "R8 ep2 arm leaves dma_en");
    wr(idx(3,0,0), 8'h01);
    expect_item(3, 0, 8'h01, "R8 dma_en on ep3 arm");
    wr(idx(3,1,0), 8'h01);
    done(2, 8'h00, 8'h00);
    expect_item(3, 0, 8'h01, "R8 ep2 done leaves dma_en");
    done(3, 8'h10, 8'h20);
    expect_item(3, 0, 8'h01, "R8 dma_en held, set B armed");
    expect_item(0, idx(3,0,0), 8'h80, "R6 ep3 set A disarmed");
    done(3, 8'h11, 8'h21);
    expect_item(3, 0, 8'h00, "R8 dma_en drops, set A idle");
    expect_item(0, idx(3,1,0), 8'h00, "R5 ep3 back on set A");
    expect_item(1, 0, 8'h06, "R10 selection vector");

    // R9: same-cycle arm write and completion on ep0 set A
    wr(idx(0,0,0), 8'h01);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = idx(0,0,0); reg_wdata = 8'h03;
    xfer_done[0] = 1'b1; xfer_status[7:0] = 8'h11; xfer_resid[7:0] = 8'h22;
    @(negedge clk);
    reg_wr = 1'b0; xfer_done = '0;
    expect_item(0, idx(0,0,0), 8'h82, "R9 completion clears arm");
    expect_item(0, idx(0,0,3), 8'h11, "R9 status loaded");

    repeat (3) @(posedge clk);
    ended = 1;
    summary();
    $finish;
  end
endmodule